// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank

This block holds the configuration bytes of a motherboard clock generator: output enables, power-down and stop behaviour, skew and slew settings, divider values and an identification byte. A serial management controller, modelled here at byte level, opens a transaction with a command byte that names the first register. The controller then either streams data bytes into consecutive registers or pulls consecutive bytes out. The active register contents drive the rest of the clock generator through a flat configuration bus.

Several bytes have special rules. Some bits of byte 0 report the live level of the frequency-select pins and the CPU stop pin. Byte 6 is a fixed identifier. Two groups of bytes are staged and committed together: the divider group (byte 9 bits 1:0, byte 10, byte 11) and the pair of bytes 12 and 13. Skew codes outside the legal range are refused. Byte 7 sets how many bytes a block read may return.

Top module: `clkgen_cfg_regs`

## Requirements
- R1: After reset, bytes hold their defaults: byte 0 stores 0x08, byte 1 0x07, byte 2 0x7F, byte 3 0xC7, byte 4 0x3F, byte 7 0x17, and bytes 16 to 19 0x04. Every other byte is 0x00.
- R2: Byte 6 always reads 0x1F, which is revision 1 in bits 7:4 and vendor code 0xF in bits 3:0. Writes to it have no effect.
- R3: A read of byte 0 returns the live frequency-select pins in bits 2:0 and the live CPU stop pin in bit 4. Writes to those four bits are dropped.
- R4: A pulse on `start` loads the register pointer from `cmd_byte`. Each `wr_valid` writes `wr_data` at the pointer and advances it. Each `rd_req` returns the byte at the pointer on `rd_data`, with `rd_valid` high, one cycle later, and advances the pointer.
- R5: Writes to byte 9 bits 1:0 and to byte 10 go to shadow storage. Shadow and written byte 11 become active together on the write of byte 11. Byte 9 bits 3:2 take effect at once.
- R6: A write to byte 12 is held in a shadow and becomes active only when byte 13 is written.
- R7: A write to bytes 16 to 19 whose bits 3:0 exceed 8 is refused and the byte keeps its previous value. `skew_err` rises and stays high until the next `start`.
- R8: Within one transaction, reads after byte-7-count reads have been returned give 0xFF. Reads of an index of 23 or above also give 0xFF.
- R9: Reserved bits are discarded on write and read as 0. The writable masks are: byte 0 0xE8, byte 1 0x7F, byte 2 0x7F, byte 4 0x3F, byte 5 0x3F, byte 8 0x3F, byte 9 0x0F, byte 13 0xE0, byte 14 0x7F, bytes 16 to 18 0x3F, byte 19 0x7F, byte 20 0x7F, byte 22 0x0F. All other bytes are fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_pins | input | 3 | Live frequency-select pin levels |
| cpu_stop_n | input | 1 | Live CPU stop pin level |
| start | input | 1 | Opens a transaction and loads the pointer |
| cmd_byte | input | 8 | Starting register index |
| wr_valid | input | 1 | Data byte to write is present |
| wr_data | input | 8 | Data byte to write |
| rd_req | input | 1 | Request for the next read byte |
| rd_valid | output | 1 | `rd_data` holds a returned byte |
| rd_data | output | 8 | Returned byte |
| skew_err | output | 1 | An illegal skew code was refused |
| cfg_q | output | 184 | Active contents of bytes 0 to 22, with byte n at bits 8n+7:8n |

## Verification
The hardest state to reach from the ports is a staged group that is half written. Byte 10, or byte 12, holds a pending value while the read-back still shows the old active value. The stimulus writes the staged bytes, reads them back while they are still pending, and only then writes the committing byte and reads again. The read-count cap is reached by programming byte 7 to a small value and reading past it within one transaction.

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs #(
  parameter logic [3:0] SKEW_LIMIT = 4'd8,
  parameter logic [7:0] ID_CODE    = 8'h1F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   fs_pins,
  input  logic         cpu_stop_n,
  input  logic         start,
  input  logic [7:0]   cmd_byte,
  input  logic         wr_valid,
  input  logic [7:0]   wr_data,
  input  logic         rd_req,
  output logic         rd_valid,
  output logic [7:0]   rd_data,
  output logic         skew_err,
  output logic [183:0] cfg_q
);
  localparam int NREG = 23;
  localparam logic [7:0] NREG_B = 8'(NREG);

  function automatic logic [7:0] wmask(input logic [4:0] i);
    case (i)
      5'd0:                       return 8'hE8;
      5'd1, 5'd2, 5'd14,
      5'd19, 5'd20:               return 8'h7F;
      5'd4, 5'd5, 5'd8,
      5'd16, 5'd17, 5'd18:        return 8'h3F;
      5'd6:                       return 8'h00;
      5'd9, 5'd22:                return 8'h0F;
      5'd13:                      return 8'hE0;
      default:                    return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] dflt(input logic [4:0] i);
    case (i)
      5'd0:                          return 8'h08;
      5'd1:                          return 8'h07;
      5'd2:                          return 8'h7F;
      5'd3:                          return 8'hC7;
      5'd4:                          return 8'h3F;
      5'd7:                          return 8'h17;
      5'd16, 5'd17, 5'd18, 5'd19:    return 8'h04;
      default:                       return 8'h00;
    endcase
  endfunction

  logic [7:0] regs [NREG];
  logic [1:0] sh9;
  logic [7:0] sh10, sh12;
  logic [7:0] ptr, rcnt;
  logic [4:0] idx;
  logic       in_range, is_skew, skew_bad;
  logic [7:0] view;

  assign idx      = ptr[4:0];
  assign in_range = ptr < NREG_B;
  assign is_skew  = idx >= 5'd16 && idx <= 5'd19;
  assign skew_bad = wr_data[3:0] > SKEW_LIMIT;

  always_comb begin
    case (idx)
      5'd0:    view = {regs[0][7:5], cpu_stop_n, regs[0][3], fs_pins};
      5'd6:    view = ID_CODE;
      default: view = regs[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(5'(i));
      sh9      <= '0;
      sh10     <= '0;
      sh12     <= '0;
      ptr      <= '0;
      rcnt     <= '0;
      skew_err <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start) begin
        ptr      <= cmd_byte;
        rcnt     <= '0;
        skew_err <= 1'b0;
      end else if (wr_valid) begin
        ptr <= ptr + 8'd1;
        if (in_range) begin
          case (idx)
            5'd9: begin
              regs[9][3:2] <= wr_data[3:2];
              sh9          <= wr_data[1:0];
            end
            5'd10: sh10 <= wr_data;
            5'd11: begin
              regs[11]     <= wr_data;
              regs[10]     <= sh10;
              regs[9][1:0] <= sh9;
            end
            5'd12: sh12 <= wr_data;
            5'd13: begin
              regs[13] <= wr_data & wmask(idx);
              regs[12] <= sh12;
            end
            default: begin
              if (is_skew && skew_bad) skew_err <= 1'b1;
              else regs[idx] <= wr_data & wmask(idx);
            end
          endcase
        end
      end else if (rd_req) begin
        ptr      <= ptr + 8'd1;
        rd_valid <= 1'b1;
        if (rcnt != 8'hFF) rcnt <= rcnt + 8'd1;
        rd_data  <= (rcnt >= regs[7] || !in_range) ? 8'hFF : view;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_q[8*g +: 8] = regs[g];
  end

  p_rd_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_req) && !$past(start) && !$past(wr_valid)));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !start && !wr_valid) |=> ptr == $past(ptr) + 8'd1);

  p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !start && ptr == 8'd10) |=> $stable(regs[10]));

  p_pair_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !start && ptr == 8'd12) |=> $stable(regs[12]));

  p_skew_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regs[16][3:0] <= SKEW_LIMIT && regs[19][3:0] <= SKEW_LIMIT);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_err && !start) |=> skew_err);
endmodule

// File: tb/clkgen_cfg_regs_test.sv
`timescale 1ns/1ps
module clkgen_cfg_regs_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] fs_pins = 3'b101;
  logic cpu_stop_n = 1, start = 0, wr_valid = 0, rd_req = 0;
  logic [7:0] cmd_byte = 0, wr_data = 0;
  logic rd_valid, skew_err;
  logic [7:0] rd_data;
  logic [183:0] cfg_q;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  clkgen_cfg_regs uut (.clk(clk), .rst_n(rst_n), .fs_pins(fs_pins), .cpu_stop_n(cpu_stop_n),
    .start(start), .cmd_byte(cmd_byte), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .skew_err(skew_err), .cfg_q(cfg_q));

  // {index, write byte, expected read-back} for reserved-bit masking (R9)
  localparam logic [23:0] VEC [12] = '{
    {8'd2, 8'hFF, 8'h7F}, {8'd4, 8'hFF, 8'h3F}, {8'd22, 8'hFF, 8'h0F},
    {8'd5, 8'hA5, 8'h25}, {8'd8, 8'hFF, 8'h3F}, {8'd14, 8'h80, 8'h00},
    {8'd21, 8'h5A, 8'h5A}, {8'd16, 8'h28, 8'h28}, {8'd20, 8'hFF, 8'h7F},
    {8'd1, 8'hFF, 8'h7F}, {8'd15, 8'h81, 8'h81}, {8'd3, 8'h00, 8'h00}};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk); @(negedge clk) rst_n = 1;
  endtask

  task automatic begin_txn(input logic [7:0] a);
    @(negedge clk) begin start = 1; cmd_byte = a; end
    @(negedge clk) start = 0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk) begin wr_valid = 1; wr_data = d; end
    @(negedge clk) wr_valid = 0;
  endtask

  task automatic get(output logic [7:0] d);
    @(negedge clk) rd_req = 1;
    @(negedge clk) rd_req = 0;
    d = rd_valid ? rd_data : 8'hXX;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d);
    begin_txn(a); get(d);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();

    // R1 reset defaults, R2 identifier, R3 live pins
    begin_txn(8'd0);
    get(d); check("R1/R3 byte0", d, 8'h1D);
    get(d); check("R1 byte1", d, 8'h07);
    get(d); check("R1 byte2", d, 8'h7F);
    get(d); check("R1 byte3", d, 8'hC7);
    get(d); check("R1 byte4", d, 8'h3F);
    get(d); check("R1 byte5", d, 8'h00);
    get(d); check("R2 byte6", d, 8'h1F);
    get(d); check("R1 byte7", d, 8'h17);
    read_at(8'd17, d); check("R1 byte17", d, 8'h04);
    check("R1 no error", {7'd0, skew_err}, 8'h00);

    // R9 table walk
    foreach (VEC[i]) begin
      begin_txn(VEC[i][23:16]); put(VEC[i][15:8]);
      read_at(VEC[i][23:16], d); check("R9 mask", d, VEC[i][7:0]);
    end

    // R3 pins follow live, writes to pin bits dropped
    do_reset();
    fs_pins = 3'b010; cpu_stop_n = 0;
    read_at(8'd0, d); check("R3 live pins", d, 8'h0A);
    begin_txn(8'd0); put(8'h17);
    read_at(8'd0, d); check("R3 write dropped", d, 8'h02);

    // R2 write ignored
    begin_txn(8'd6); put(8'h00);
    read_at(8'd6, d); check("R2 write ignored", d, 8'h1F);

    // R4 block write and block read
    begin_txn(8'd14); put(8'h11); put(8'h22); put(8'h33);
    begin_txn(8'd14);
    get(d); check("R4 burst 0", d, 8'h11);
    get(d); check("R4 burst 1", d, 8'h22);
    get(d); check("R4 burst 2", d, 8'h33);

    // R5 staged divider group
    begin_txn(8'd9); put(8'h0F); put(8'hAB);
    read_at(8'd9, d);  check("R5 byte9 partial", d, 8'h0C);
    read_at(8'd10, d); check("R5 byte10 pending", d, 8'h00);
    begin_txn(8'd11); put(8'h80);
    read_at(8'd9, d);  check("R5 byte9 commit", d, 8'h0F);
    read_at(8'd10, d); check("R5 byte10 commit", d, 8'hAB);
    read_at(8'd11, d); check("R5 byte11", d, 8'h80);

    // R6 pair 12/13
    begin_txn(8'd12); put(8'h55);
    read_at(8'd12, d); check("R6 byte12 pending", d, 8'h00);
    begin_txn(8'd13); put(8'hFF);
    read_at(8'd13, d); check("R6 byte13", d, 8'hE0);
    read_at(8'd12, d); check("R6 byte12 commit", d, 8'h55);

    // R7 illegal skew codes
    do_reset();
    begin_txn(8'd16); put(8'h09);
    check("R7 error set", {7'd0, skew_err}, 8'h01);
    read_at(8'd16, d); check("R7 value kept", d, 8'h04);
    check("R7 error cleared", {7'd0, skew_err}, 8'h00);
    begin_txn(8'd16); put(8'h08);
    check("R7 legal no error", {7'd0, skew_err}, 8'h00);
    read_at(8'd16, d); check("R7 legal code", d, 8'h08);
    begin_txn(8'd19); put(8'h4F);
    read_at(8'd19, d); check("R7 byte19 kept", d, 8'h04);

    // R8 read count cap and out-of-range index
    begin_txn(8'd7); put(8'h02);
    begin_txn(8'd0);
    get(d); check("R8 first", d, {5'b00001, fs_pins} | {3'b000, cpu_stop_n, 4'b0000});
    get(d); check("R8 second", d, 8'h07);
    get(d); check("R8 capped", d, 8'hFF);
    do_reset();
    begin_txn(8'd22);
    get(d); check("R8 last byte", d, 8'h00);
    get(d); check("R8 past end", d, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule